// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-visible register file of an Ethernet DMA controller. It takes word-aligned reads and writes from a simple 32-bit register bus. It holds the configuration words of the DMA engine: bus mode, the receive and transmit list bases, the current descriptor pointers, control and interrupt enable. It also holds a sticky status word that the transmit and receive engines set with single-cycle event pulses.

An interrupt line is raised while any enabled status bit is set. Software acknowledges the interrupt by writing ones to the status bits it has handled. Writing the poll-demand word produces a one-cycle kick for the transmit descriptor engine. The current descriptor pointers and the receive-enable bit are driven out to the engines.

A request is taken when `bus_valid` is high at a rising clock edge. A write takes effect at that edge. Read data is returned in the following cycle, with `bus_rvalid` high.

Top module: `dma_csr_regs`

## Requirements
- R1: After synchronous reset every stored register, both descriptor pointers, `irq`, `tx_kick`, `rx_enable`, `bus_rvalid` and `bus_rdata` are zero.
- R2: The register word index is the byte address shifted right by two. Bus mode is at index 0x3C0, poll demand at 0x3C1, receive base at 0x3C3, transmit base at 0x3C4, status at 0x3C5, control at 0x3C6, interrupt enable at 0x3C7, current transmit pointer at 0x3D2, current receive pointer at 0x3D3 and version at 0x008. Control, interrupt enable and both bases read back the last value written.
- R3: A write to bus mode stores bit 0 as zero and all other bits as written.
- R4: A write to the receive (transmit) base also loads the current receive (transmit) pointer with the same value. A direct write to a current pointer loads only that pointer. Both pointers are driven on `rx_desc_ptr` and `tx_desc_ptr` from the cycle after the write.
- R5: A write to status clears each status bit that is 1 in the write data and leaves the other bits unchanged.
- R6: Each event pulse sets two status bits. `evt_tx_done` sets bits 0 and 16. `evt_rx_done` sets bits 6 and 16. `evt_rx_nobuf` sets bits 7 and 15.
- R7: An event pulse in the same cycle as a status clear write leaves the event's bits set.
- R8: `irq` is high exactly when the bitwise AND of status and interrupt enable is non-zero, as those registers stand after the latest edge.
- R9: A write to poll demand stores nothing; it reads as zero and drives `tx_kick` high for exactly the one cycle after the write.
- R10: A read of the version index returns 0x00001012 whatever was written there.
- R11: `rx_enable` equals bit 1 of the control register.
- R12: Reads of unmapped indices, or of any address whose two low bits are not zero, return zero. Writes to such addresses change nothing.
- R13: `bus_rvalid` is high in the cycle after each read request and low otherwise. `bus_rdata` is zero whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| evt_tx_done | input | 1 | Transmit frame completed pulse |
| evt_rx_done | input | 1 | Receive frame completed pulse |
| evt_rx_nobuf | input | 1 | Receive buffer unavailable pulse |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | One-cycle transmit scan start |
| rx_enable | output | 1 | Receive enabled |
| rx_desc_ptr | output | 32 | Current receive descriptor pointer |
| tx_desc_ptr | output | 32 | Current transmit descriptor pointer |

## Verification
A software write-one-to-clear of the status word and a hardware event pulse can land on the same clock edge, and they compete for the same bits. The bench provokes this with directed cases: it writes all ones to status in the cycle an event arrives. It also raises events at random during a long run of random register traffic. Each outcome is judged against a bench model that applies the clear first and the event second, with the interrupt level recomputed from the model's status and enable words.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 16;

    localparam logic [IDX_W-1:0] IDX_VERSION = 16'h0008;
    localparam logic [IDX_W-1:0] IDX_BUSMODE = 16'h03C0;
    localparam logic [IDX_W-1:0] IDX_POLL    = 16'h03C1;
    localparam logic [IDX_W-1:0] IDX_RXBASE  = 16'h03C3;
    localparam logic [IDX_W-1:0] IDX_TXBASE  = 16'h03C4;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 16'h03C5;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 16'h03C6;
    localparam logic [IDX_W-1:0] IDX_IEN     = 16'h03C7;
    localparam logic [IDX_W-1:0] IDX_CURTX   = 16'h03D2;
    localparam logic [IDX_W-1:0] IDX_CURRX   = 16'h03D3;

    localparam int ST_TX_DONE  = 0;
    localparam int ST_RX_DONE  = 6;
    localparam int ST_RX_NOBUF = 7;
    localparam int ST_ABN_SUM  = 15;
    localparam int ST_NRM_SUM  = 16;
    localparam int CTRL_RX_EN  = 1;

    localparam logic [DATA_W-1:0] VERSION_VALUE = 32'h0000_1012;
    localparam logic [DATA_W-1:0] BUSMODE_WMASK = 32'hFFFF_FFFE;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VERSION, SEL_BUSMODE, SEL_POLL, SEL_RXBASE, SEL_TXBASE,
        SEL_STATUS, SEL_CTRL, SEL_IEN, SEL_CURTX, SEL_CURRX
    } csr_sel_e;

    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        csr_sel_e          sel;
        logic [DATA_W-1:0] data;
    } csr_access_t;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic rx_nobuf;
    } dma_evt_t;

    function automatic csr_sel_e decode_index(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_VERSION: return SEL_VERSION;
            IDX_BUSMODE: return SEL_BUSMODE;
            IDX_POLL:    return SEL_POLL;
            IDX_RXBASE:  return SEL_RXBASE;
            IDX_TXBASE:  return SEL_TXBASE;
            IDX_STATUS:  return SEL_STATUS;
            IDX_CTRL:    return SEL_CTRL;
            IDX_IEN:     return SEL_IEN;
            IDX_CURTX:   return SEL_CURTX;
            IDX_CURRX:   return SEL_CURRX;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] event_bits(input dma_evt_t e);
        logic [DATA_W-1:0] b;
        b = '0;
        if (e.tx_done) begin
            b[ST_TX_DONE] = 1'b1;
            b[ST_NRM_SUM] = 1'b1;
        end
        if (e.rx_done) begin
            b[ST_RX_DONE] = 1'b1;
            b[ST_NRM_SUM] = 1'b1;
        end
        if (e.rx_nobuf) begin
            b[ST_RX_NOBUF] = 1'b1;
            b[ST_ABN_SUM]  = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   valid,
    input  logic                   write,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output csr_access_t            acc
);
    localparam int WIDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] idx;

    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = IDX_W'(addr[ADDR_W-1:2]);

    always_comb begin
        acc.wr_en = valid && write;
        acc.rd_en = valid && !write;
        acc.sel   = aligned ? decode_index(idx) : SEL_NONE;
        acc.data  = wdata;
    end

    if (WIDX_W > IDX_W) begin : g_width_guard
        initial $error("address width too large for index decode");
    end
endmodule

// File: rtl/dmacsr_word.sv
module dmacsr_word #(
    parameter int               W         = 32,
    parameter logic [W-1:0]     RESET_VAL = '0,
    parameter logic [W-1:0]     WMASK     = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= RESET_VAL;
        else if (we) q <= wdata & WMASK;
    end
endmodule

// File: rtl/dmacsr_status.sv
module dmacsr_status
    import dmacsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_bits,
    input  dma_evt_t          evt,
    input  logic [DATA_W-1:0] enable,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic [DATA_W-1:0] kept;
    logic [DATA_W-1:0] status_d;

    always_comb begin
        kept     = clr_we ? (status & ~clr_bits) : status;
        status_d = kept | event_bits(evt);
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_d;
    end

    assign irq = |(status & enable);
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dmacsr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              evt_tx_done,
    input  logic              evt_rx_done,
    input  logic              evt_rx_nobuf,
    output logic              irq,
    output logic              tx_kick,
    output logic              rx_enable,
    output logic [31:0]       rx_desc_ptr,
    output logic [31:0]       tx_desc_ptr
);
    csr_access_t       acc;
    dma_evt_t          evt;
    logic [DATA_W-1:0] busmode_q, rxbase_q, txbase_q, ctrl_q, ien_q, status_q;
    logic [DATA_W-1:0] rd_mux;

    assign evt = '{tx_done: evt_tx_done, rx_done: evt_rx_done, rx_nobuf: evt_rx_nobuf};

    dmacsr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .acc   (acc)
    );

    dmacsr_word #(.W(DATA_W), .WMASK(BUSMODE_WMASK)) u_busmode (
        .clk(clk), .rst(rst), .we(acc.wr_en && acc.sel == SEL_BUSMODE),
        .wdata(acc.data), .q(busmode_q));
    dmacsr_word #(.W(DATA_W)) u_rxbase (
        .clk(clk), .rst(rst), .we(acc.wr_en && acc.sel == SEL_RXBASE),
        .wdata(acc.data), .q(rxbase_q));
    dmacsr_word #(.W(DATA_W)) u_txbase (
        .clk(clk), .rst(rst), .we(acc.wr_en && acc.sel == SEL_TXBASE),
        .wdata(acc.data), .q(txbase_q));
    dmacsr_word #(.W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .we(acc.wr_en && acc.sel == SEL_CTRL),
        .wdata(acc.data), .q(ctrl_q));
    dmacsr_word #(.W(DATA_W)) u_ien (
        .clk(clk), .rst(rst), .we(acc.wr_en && acc.sel == SEL_IEN),
        .wdata(acc.data), .q(ien_q));

    dmacsr_status u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_we   (acc.wr_en && acc.sel == SEL_STATUS),
        .clr_bits (acc.data),
        .evt      (evt),
        .enable   (ien_q),
        .status   (status_q),
        .irq      (irq)
    );

    // Current descriptor pointers: reloaded from a base write or written directly.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_desc_ptr <= '0;
            tx_desc_ptr <= '0;
        end else if (acc.wr_en) begin
            if (acc.sel == SEL_RXBASE || acc.sel == SEL_CURRX) rx_desc_ptr <= acc.data;
            if (acc.sel == SEL_TXBASE || acc.sel == SEL_CURTX) tx_desc_ptr <= acc.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tx_kick <= 1'b0;
        else     tx_kick <= acc.wr_en && acc.sel == SEL_POLL;
    end

    assign rx_enable = ctrl_q[CTRL_RX_EN];

    always_comb begin
        case (acc.sel)
            SEL_VERSION: rd_mux = VERSION_VALUE;
            SEL_BUSMODE: rd_mux = busmode_q;
            SEL_RXBASE:  rd_mux = rxbase_q;
            SEL_TXBASE:  rd_mux = txbase_q;
            SEL_STATUS:  rd_mux = status_q;
            SEL_CTRL:    rd_mux = ctrl_q;
            SEL_IEN:     rd_mux = ien_q;
            SEL_CURTX:   rd_mux = tx_desc_ptr;
            SEL_CURRX:   rd_mux = rx_desc_ptr;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= acc.rd_en;
            bus_rdata  <= acc.rd_en ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/dma_csr_regs_chk.sv
module dma_csr_regs_chk
    import dmacsr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              evt_tx_done,
    input logic              evt_rx_done,
    input logic              evt_rx_nobuf,
    input logic              irq,
    input logic              tx_kick,
    input logic              rx_enable,
    input logic [31:0]       tx_desc_ptr
);
    logic [IDX_W-1:0] idx;
    logic             al, wr, rd, any_evt;

    assign idx     = IDX_W'(bus_addr[ADDR_W-1:2]);
    assign al      = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_valid && bus_write && al;
    assign rd      = bus_valid && !bus_write && al;
    assign any_evt = evt_tx_done || evt_rx_done || evt_rx_nobuf;

    assert_kick_after_poll_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && idx == IDX_POLL) |=> tx_kick);
    assert_kick_only_poll_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && idx == IDX_POLL) |=> !tx_kick);
    assert_version_const_R10: assert property (@(posedge clk) disable iff (rst)
        (rd && idx == IDX_VERSION) |=> (bus_rdata == VERSION_VALUE));
    assert_busmode_bit0_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && idx == IDX_BUSMODE) |=> !bus_rdata[0]);
    assert_txptr_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && (idx == IDX_TXBASE || idx == IDX_CURTX)) |=> (tx_desc_ptr == $past(bus_wdata)));
    assert_rxen_source_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_enable) |-> $past(wr && idx == IDX_CTRL));
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((bus_valid && bus_write) || any_evt));
    assert_rvalid_follow_R13: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);
    assert_rdata_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> (bus_rdata == '0));
endmodule

bind dma_csr_regs dma_csr_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_csr_regs_test.sv
module dma_csr_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_valid = 0, bus_write = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic evt_tx_done = 0, evt_rx_done = 0, evt_rx_nobuf = 0;
    logic irq, tx_kick, rx_enable;
    logic [31:0] rx_desc_ptr, tx_desc_ptr;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model of the register file
    logic [31:0] m_bus, m_rxb, m_txb, m_st, m_ctl, m_ien, m_rxp, m_txp;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_csr_regs #(.ADDR_W(AW)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[AW-1:2])
            10'h008: return 32'h0000_1012;
            10'h3C0: return m_bus;
            10'h3C3: return m_rxb;
            10'h3C4: return m_txb;
            10'h3C5: return m_st;
            10'h3C6: return m_ctl;
            10'h3C7: return m_ien;
            10'h3D2: return m_txp;
            10'h3D3: return m_rxp;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00) return "R12 misaligned read";
        case (a[AW-1:2])
            10'h008: return "R10 version read";
            10'h3C0: return "R3 busmode read";
            10'h3C1: return "R9 poll read";
            10'h3C3, 10'h3C4, 10'h3D2, 10'h3D3: return "R4 pointer/base read";
            10'h3C5: return "R5 R6 status read";
            10'h3C6, 10'h3C7: return "R2 read back";
            default: return "R12 unmapped read";
        endcase
    endfunction

    function automatic logic [31:0] evt_bits(input bit e0, input bit e1, input bit e2);
        logic [31:0] b = 32'h0;
        if (e0) b |= 32'h0001_0001;
        if (e1) b |= 32'h0001_0040;
        if (e2) b |= 32'h0000_8080;
        return b;
    endfunction

    // One bus cycle; outputs checked 1 time unit after the edge.
    task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                        input logic [31:0] d, input bit e0, input bit e1, input bit e2);
        logic [31:0] exp_rd;
        bit          exp_kick;
        string       tag;
        exp_rd   = (v && !w) ? model_read(a) : 32'h0;
        tag      = read_tag(a);
        exp_kick = v && w && a == 12'hF04;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        evt_tx_done = e0; evt_rx_done = e1; evt_rx_nobuf = e2;
        @(posedge clk);
        #1;
        bus_valid = 0; bus_write = 0;
        evt_tx_done = 0; evt_rx_done = 0; evt_rx_nobuf = 0;
        if (v && w && a[1:0] == 2'b00) begin
            case (a[AW-1:2])
                10'h3C0: m_bus = d & 32'hFFFF_FFFE;
                10'h3C3: begin m_rxb = d; m_rxp = d; end
                10'h3C4: begin m_txb = d; m_txp = d; end
                10'h3C5: m_st = m_st & ~d;
                10'h3C6: m_ctl = d;
                10'h3C7: m_ien = d;
                10'h3D2: m_txp = d;
                10'h3D3: m_rxp = d;
                default: ;
            endcase
        end
        m_st |= evt_bits(e0, e1, e2);
        chk("R13 rvalid", {31'h0, bus_rvalid}, {31'h0, v && !w});
        chk(tag, bus_rdata, exp_rd);
        chk("R8 irq level", {31'h0, irq}, {31'h0, |(m_st & m_ien)});
        chk("R9 tx_kick", {31'h0, tx_kick}, {31'h0, exp_kick});
        chk("R11 rx_enable", {31'h0, rx_enable}, {31'h0, m_ctl[1]});
        chk("R4 rx_desc_ptr", rx_desc_ptr, m_rxp);
        chk("R4 tx_desc_ptr", tx_desc_ptr, m_txp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        step(1, 0, a, 32'h0, 0, 0, 0);
    endtask

    function automatic logic [AW-1:0] pick_addr(input int unsigned r);
        case (r)
            0: return 12'hF00;  1: return 12'hF04;  2: return 12'hF0C;
            3: return 12'hF10;  4: return 12'hF14;  5: return 12'hF18;
            6: return 12'hF1C;  7: return 12'hF48;  8: return 12'hF4C;
            9: return 12'h020;  10: return 12'hF14;
            11: return AW'($urandom) & 12'hFFC;
            default: return AW'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        {m_bus, m_rxb, m_txb, m_st, m_ctl, m_ien, m_rxp, m_txp} = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 tx_kick", {31'h0, tx_kick}, 32'h0);
        chk("R1 rx_enable", {31'h0, rx_enable}, 32'h0);
        chk("R1 pointers", rx_desc_ptr | tx_desc_ptr, 32'h0);
        rd(12'hF14); rd(12'hF18); rd(12'hF00);
        // R3 bus mode bit 0
        wr(12'hF00, 32'hFFFF_FFFF); rd(12'hF00);
        // R4 base reloads pointer, direct pointer write
        wr(12'hF10, 32'h0000_1000); rd(12'hF48);
        wr(12'hF4C, 32'h0000_2000); rd(12'hF0C);
        wr(12'hF0C, 32'h0000_3000); rd(12'hF4C);
        // R6 events, R8 irq
        step(0, 0, 0, 0, 1, 0, 0); rd(12'hF14);
        wr(12'hF1C, 32'h0000_0001);
        step(0, 0, 0, 0, 0, 1, 1); rd(12'hF14);
        // R5 write one to clear
        wr(12'hF14, 32'h0000_0001); rd(12'hF14);
        chk("R5 status after clear", m_st, 32'h0001_80C0);
        // R7 clear and event on the same edge
        step(1, 1, 12'hF14, 32'hFFFF_FFFF, 0, 1, 0); rd(12'hF14);
        chk("R7 event survives clear", m_st, 32'h0001_0040);
        step(1, 1, 12'hF14, 32'hFFFF_FFFF, 1, 1, 1); rd(12'hF14);
        // R10 version constant
        wr(12'h020, 32'h0000_0000); rd(12'h020);
        // R9 poll: pulse then nothing stored
        wr(12'hF04, 32'hFFFF_FFFF); rd(12'hF04); wr(12'hF04, 32'h1); wr(12'hF04, 32'h1);
        // R11 receive enable
        wr(12'hF18, 32'h0000_0002); wr(12'hF18, 32'hFFFF_FFFD);
        // R12 unmapped and misaligned writes ignored
        wr(12'h400, 32'h2222_2222); rd(12'h400);
        wr(12'hF19, 32'h0000_0002); rd(12'hF18); rd(12'hF19);
        wr(12'hF11, 32'h5555_5555); rd(12'hF10);
        // random traffic with events
        for (int i = 0; i < 4000; i++) begin
            int unsigned kind = $urandom_range(0, 12);
            bit v = ($urandom_range(0, 7) != 0);
            bit w = $urandom_range(0, 1);
            logic [31:0] d = $urandom;
            if (kind == 4 || kind == 10) d = d & $urandom & $urandom;
            step(v, w, pick_addr(kind), d,
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 5) == 0);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule